// File: doc/BRIEF.md
# Wake Interrupt Pending Aggregator

This block collects the interrupt lines that are allowed to wake a sleeping system and folds them into one set of top-level pending bits. Three kinds of source feed it. A non-maskable request pin passes through a programmable edge or level detector into a sticky latch on top-level bit 0. Fifteen direct lines sit on bits 1 to 15. A small set of banked direct lines follows them. Multiplexed lines are masked one by one and then folded in groups of eight, one top-level bit per group. Every pending bit is gated by its own enable bit.

The direct and multiplexed lines are also passed straight through to the parent interrupt controller, whatever their enables say. The banked lines have no parent output. The latch output drives the parent's non-maskable input. A power controller watches `wake_o`, which is the registered OR of all enabled pending bits. Software reaches the block through a 32-bit register port with one write strobe and a combinational read.

The parameter `EXTENDED` chooses between two configurations. In the base configuration there are three banked bits and thirteen groups on bits 19 to 31, and only part of the mux array is implemented. In the extended configuration there are five banked bits and sixteen groups starting at bit 21, and every mux bit is implemented.

Top module: `wake_irq_agg`

## Requirements
- R1: After reset, every enable word and every mux-enable word reads 0, the trigger register reads 2, and `wake_o` and `nmi_o` are 0.
- R2: `direct_irq_o` always equals `direct_src_i`. Pending bit k (k = 1..15) reads `direct_src_i[k-1]` AND enable bit k.
- R3: Trigger register 0x0C, bits [1:0]: 0 = level low, 1 = falling edge, 2 = level high, 3 = rising edge. A qualifying pin event sets the latch, and `nmi_o` shows it one clock later. The latch holds until it is cleared.
- R4: Writing 1 to bit 0 at 0x10 clears the latch, unless the set condition is true in the same cycle. Pending bit 0 reads the latch AND enable bit 0.
- R5: Banked bits start at top-level bit 16 (3 bits in the base configuration). Each pending bit reads source AND enable, and the banked bits have no parent output.
- R6: Group g reads as top-level bit 19+g in the base configuration. It is the OR of `mux_src_i[8g+j] & mux-enable[8g+j]` over j = 0..7, gated by its enable bit. `mux_irq_o` always equals `mux_src_i`.
- R7: Unimplemented mux bits drop writes, read 0 and never contribute. In the base configuration the implemented bits are 0-31, 51-95 and 96-99.
- R8: Writes to pending words change nothing except the latch clear. Pending bits above the last group read 0.
- R9: `wake_o` is the OR of all enabled pending bits, taken one clock earlier.
- R10: Register offsets are: trigger 0x0C; pending 0x10 and 0x14; enable 0x40 and 0x44; mux-enable 0xC0, 0xC4, 0xC8 and 0xCC. All other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register byte offset |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data |
| nmi_pin_i | input | 1 | Non-maskable request pin |
| direct_src_i | input | 15 | Direct sources for top-level bits 1..15 |
| banked_src_i | input | NUM_BANKED (3, or 5 when extended) | Banked direct sources |
| mux_src_i | input | 128 | Multiplexed sources |
| nmi_o | output | 1 | Latch state, sent to the parent |
| direct_irq_o | output | 15 | Direct lines passed to the parent |
| mux_irq_o | output | 128 | Mux lines passed to the parent |
| wake_o | output | 1 | Registered wake request |

## Verification
The hardest case is the clear that loses against a set in the same cycle. The stimulus holds the pin at its active level, or leaves it just past an edge, while the clear is written, and it does this in every trigger mode. It then checks that level modes keep `nmi_o` high and edge modes let it drop. Mode switches are timed so that the cycle still running under the old mode is accounted for. The ragged edges of the implemented mux set are reached by driving sources on mux bits 99 and 100 and on bits 32 and 51, with all enables set to ones.

// File: rtl/wake_irq_pkg.sv
package wake_irq_pkg;
  localparam int TOP_BITS    = 64;
  localparam int MUX_BITS    = 128;
  localparam int GRP_W       = 8;
  localparam int NUM_DIRECT  = 15;
  localparam int BANKED_BASE = NUM_DIRECT + 1;
  localparam int TOP_WORDS   = TOP_BITS / 32;
  localparam int MUX_WORDS   = MUX_BITS / 32;

  localparam logic [7:0] ADDR_TRIG  = 8'h0c;
  localparam logic [7:0] ADDR_PEND  = 8'h10;
  localparam logic [7:0] ADDR_EN    = 8'h40;
  localparam logic [7:0] ADDR_MUXEN = 8'hc0;

  typedef enum logic [1:0] {
    TRIG_LVL_LO = 2'd0,
    TRIG_FALL   = 2'd1,
    TRIG_LVL_HI = 2'd2,
    TRIG_RISE   = 2'd3
  } trig_e;

  function automatic logic [MUX_BITS-1:0] mux_valid(bit ext);
    if (ext) return '1;
    return 128'h0000000f_ffffffff_fff80000_ffffffff;
  endfunction
endpackage

// File: rtl/wake_irq_nmi_latch.sv
module wake_irq_nmi_latch
  import wake_irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pin_i,
  input  trig_e trig_i,
  input  logic  clr_i,
  output logic  latch_o
);
  logic pin_q, latch_q, set;

  always_comb begin
    unique case (trig_i)
      TRIG_LVL_LO: set = ~pin_i;
      TRIG_FALL:   set = ~pin_i & pin_q;
      TRIG_LVL_HI: set = pin_i;
      default:     set = pin_i & ~pin_q;
    endcase
  end

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q   <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      pin_q <= pin_i;
      if (set)        latch_q <= 1'b1;
      else if (clr_i) latch_q <= 1'b0;
    end
  end

  assign latch_o = latch_q;

  a_r3_latch_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_q && !clr_i |=> latch_q);
  a_r4_fall_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(latch_q) |-> $past(clr_i));
endmodule

// File: rtl/wake_irq_mux_fold.sv
module wake_irq_mux_fold
  import wake_irq_pkg::*;
#(
  parameter int NUM_GROUPS = 13,
  localparam int FOLD_BITS = NUM_GROUPS * GRP_W
) (
  input  logic [FOLD_BITS-1:0]  src_i,
  input  logic [FOLD_BITS-1:0]  en_i,
  output logic [NUM_GROUPS-1:0] grp_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_o[g] = |(src_i[g*GRP_W +: GRP_W] & en_i[g*GRP_W +: GRP_W]);
  end
endmodule

// File: rtl/wake_irq_regs.sv
module wake_irq_regs
  import wake_irq_pkg::*;
#(
  parameter logic [MUX_BITS-1:0] VALID = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [7:0]          addr_i,
  input  logic                we_i,
  input  logic [31:0]         wdata_i,
  input  logic [TOP_BITS-1:0] pend_i,
  output logic [31:0]         rdata_o,
  output logic [TOP_BITS-1:0] en_o,
  output logic [MUX_BITS-1:0] mux_en_o,
  output trig_e               trig_o,
  output logic                nmi_clr_o
);
  logic [TOP_BITS-1:0] en_q;
  logic [MUX_BITS-1:0] mux_en_q;
  trig_e               trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      mux_en_q <= '0;
      trig_q   <= TRIG_LVL_HI;
    end else if (we_i) begin
      if (addr_i == ADDR_TRIG) trig_q <= trig_e'(wdata_i[1:0]);
      for (int i = 0; i < TOP_WORDS; i++)
        if (addr_i == ADDR_EN + 8'(4 * i)) en_q[i*32 +: 32] <= wdata_i;
      for (int i = 0; i < MUX_WORDS; i++)
        if (addr_i == ADDR_MUXEN + 8'(4 * i))
          mux_en_q[i*32 +: 32] <= wdata_i & VALID[i*32 +: 32];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_TRIG) rdata_o = {30'd0, trig_q};
    for (int i = 0; i < TOP_WORDS; i++) begin
      if (addr_i == ADDR_PEND + 8'(4 * i)) rdata_o = pend_i[i*32 +: 32];
      if (addr_i == ADDR_EN + 8'(4 * i))   rdata_o = en_q[i*32 +: 32];
    end
    for (int i = 0; i < MUX_WORDS; i++)
      if (addr_i == ADDR_MUXEN + 8'(4 * i)) rdata_o = mux_en_q[i*32 +: 32];
  end

  assign nmi_clr_o = we_i && (addr_i == ADDR_PEND) && wdata_i[0];
  assign en_o      = en_q;
  assign mux_en_o  = mux_en_q;
  assign trig_o    = trig_q;

  a_r7_invalid_mux_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_en_q & ~VALID) == '0);
endmodule

// File: rtl/wake_irq_agg.sv
module wake_irq_agg
  import wake_irq_pkg::*;
#(
  parameter bit EXTENDED = 1'b0,
  localparam int NUM_BANKED = EXTENDED ? 5 : 3,
  localparam int NUM_GROUPS = EXTENDED ? 16 : 13
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [7:0]            reg_addr_i,
  input  logic                  reg_we_i,
  input  logic [31:0]           reg_wdata_i,
  output logic [31:0]           reg_rdata_o,
  input  logic                  nmi_pin_i,
  input  logic [NUM_DIRECT-1:0] direct_src_i,
  input  logic [NUM_BANKED-1:0] banked_src_i,
  input  logic [MUX_BITS-1:0]   mux_src_i,
  output logic                  nmi_o,
  output logic [NUM_DIRECT-1:0] direct_irq_o,
  output logic [MUX_BITS-1:0]   mux_irq_o,
  output logic                  wake_o
);
  localparam int MUX_BASE = BANKED_BASE + NUM_BANKED;
  localparam int FOLD_BITS = NUM_GROUPS * GRP_W;
  localparam logic [MUX_BITS-1:0] MUX_VALID = mux_valid(EXTENDED);

  logic [TOP_BITS-1:0]   en, pend_raw, pend;
  logic [MUX_BITS-1:0]   mux_en;
  logic [NUM_GROUPS-1:0] grp;
  trig_e                 trig;
  logic                  nmi_clr, latch, wake_q;

  wake_irq_regs #(.VALID(MUX_VALID)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .pend_i(pend), .rdata_o(reg_rdata_o),
    .en_o(en), .mux_en_o(mux_en), .trig_o(trig), .nmi_clr_o(nmi_clr)
  );

  wake_irq_nmi_latch u_nmi (
    .clk_i, .rst_ni, .pin_i(nmi_pin_i), .trig_i(trig),
    .clr_i(nmi_clr), .latch_o(latch)
  );

  wake_irq_mux_fold #(.NUM_GROUPS(NUM_GROUPS)) u_fold (
    .src_i(mux_src_i[FOLD_BITS-1:0]),
    .en_i(mux_en[FOLD_BITS-1:0]),
    .grp_o(grp)
  );

  always_comb begin
    pend_raw                            = '0;
    pend_raw[0]                         = latch;
    pend_raw[NUM_DIRECT:1]              = direct_src_i;
    pend_raw[BANKED_BASE +: NUM_BANKED] = banked_src_i;
    pend_raw[MUX_BASE +: NUM_GROUPS]    = grp;
  end
  assign pend = pend_raw & en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_q <= 1'b0;
    else         wake_q <= |pend;
  end

  assign wake_o       = wake_q;
  assign nmi_o        = latch;
  assign direct_irq_o = direct_src_i;
  assign mux_irq_o    = mux_src_i;

  a_r9_wake_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_raw & en)) |=> wake_o);
  a_r9_wake_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |=> !wake_o);
endmodule

// File: tb/wake_irq_agg_tb.sv
`timescale 1ns/1ps
module wake_irq_agg_tb;
  logic         clk = 1'b0, rst_ni = 1'b0;
  logic [7:0]   addr = '0;
  logic         we = 1'b0;
  logic [31:0]  wdata = '0, rdata;
  logic         pin = 1'b0;
  logic [14:0]  dsrc = '0;
  logic [2:0]   bsrc = '0;
  logic [127:0] msrc = '0;
  logic         nmi, wake;
  logic [14:0]  dirq;
  logic [127:0] mirq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wake_irq_agg u_dut (
    .clk_i(clk), .rst_ni, .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .nmi_pin_i(pin), .direct_src_i(dsrc), .banked_src_i(bsrc),
    .mux_src_i(msrc), .nmi_o(nmi), .direct_irq_o(dirq), .mux_irq_o(mirq), .wake_o(wake)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic rchk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d); chk(req, d, exp);
  endtask

  task automatic t_reset;
    chk("R1 wake", 32'(wake), 0);
    chk("R1 nmi", 32'(nmi), 0);
    rchk("R1 trig", 8'h0c, 2);
    for (int i = 0; i < 2; i++) rchk("R1 en", 8'(8'h40 + 4*i), 0);
    for (int i = 0; i < 4; i++) rchk("R1 muxen", 8'(8'hc0 + 4*i), 0);
  endtask

  task automatic t_direct;
    dsrc = 15'h5555;
    wr(8'h40, 32'h0000fffe);
    chk("R2 passthrough", 32'(dirq), 32'h5555);
    rchk("R2 pend all", 8'h10, 32'h0000aaaa);
    wr(8'h40, 32'h00000002);
    rchk("R2 pend gated", 8'h10, 32'h2);
    dsrc = '0;
  endtask

  task automatic t_banked;
    bsrc = 3'b101;
    wr(8'h40, 32'h00070000);
    rchk("R5 banked pend", 8'h10, 32'h00050000);
    wr(8'h40, 32'h00010000);
    rchk("R5 banked gated", 8'h10, 32'h00010000);
    bsrc = '0;
  endtask

  task automatic t_mux;
    wr(8'hc0, 32'h000000f0);
    wr(8'h40, 32'h00180000);
    msrc = '0; msrc[2] = 1'b1;
    rchk("R6 masked src", 8'h10, 0);
    chk("R6 passthrough", mirq[31:0], 32'h4);
    msrc = '0; msrc[5] = 1'b1;
    rchk("R6 group0", 8'h10, 32'h00080000);
    msrc = '0; msrc[12] = 1'b1;
    rchk("R6 group1 masked", 8'h10, 0);
    wr(8'hc0, 32'h0000f0f0);
    rchk("R6 group1", 8'h10, 32'h00100000);
    wr(8'h40, 32'h00080000);
    rchk("R6 group gated", 8'h10, 0);
    msrc = '0;
  endtask

  task automatic t_invalid;
    wr(8'hc4, 32'hffffffff);
    rchk("R7 word1 mask", 8'hc4, 32'hfff80000);
    wr(8'hcc, 32'hffffffff);
    rchk("R7 word3 mask", 8'hcc, 32'h0000000f);
    wr(8'hc8, 32'hffffffff);
    wr(8'h40, 32'h82800000);
    msrc = '0; msrc[32] = 1'b1;
    rchk("R7 bit32 dead", 8'h10, 0);
    msrc = '0; msrc[51] = 1'b1;
    rchk("R7 bit51 live", 8'h10, 32'h02000000);
    msrc = '0; msrc[100] = 1'b1;
    rchk("R7 bit100 dead", 8'h10, 0);
    msrc = '0; msrc[99] = 1'b1;
    rchk("R7 bit99 live", 8'h10, 32'h80000000);
    msrc = '0;
    wr(8'h40, 0);
  endtask

  task automatic t_pend_ro;
    dsrc = 15'h1;
    wr(8'h40, 32'h0000fffe);
    wr(8'h10, 32'hfffffffe);
    rchk("R8 pend write ignored", 8'h10, 32'h2);
    wr(8'h44, 32'hffffffff);
    rchk("R8 en1 stored", 8'h44, 32'hffffffff);
    wr(8'h14, 32'hffffffff);
    rchk("R8 upper pend zero", 8'h14, 0);
    wr(8'h44, 0);
    wr(8'h40, 0);
    dsrc = '0;
  endtask

  task automatic t_unmapped;
    wr(8'h40, 32'h12345678);
    rchk("R10 en0 map", 8'h40, 32'h12345678);
    rchk("R10 off 00", 8'h00, 0);
    rchk("R10 off 20", 8'h20, 0);
    rchk("R10 off 48", 8'h48, 0);
    rchk("R10 off d0", 8'hd0, 0);
    rchk("R10 off 42", 8'h42, 0);
    wr(8'h40, 0);
  endtask

  task automatic t_nmi;
    wr(8'h40, 32'h1);
    chk("R3 idle", 32'(nmi), 0);
    @(negedge clk); pin = 1'b1;
    @(negedge clk);
    chk("R3 level high set", 32'(nmi), 1);
    rchk("R4 pend bit0", 8'h10, 1);
    wr(8'h10, 1);
    chk("R4 clear loses to level", 32'(nmi), 1);
    pin = 1'b0;
    wr(8'h10, 1);
    chk("R4 clear", 32'(nmi), 0);
    @(negedge clk);
    chk("R4 stays clear", 32'(nmi), 0);
    wr(8'h0c, 3);
    @(negedge clk); pin = 1'b1;
    @(negedge clk);
    chk("R3 rising set", 32'(nmi), 1);
    wr(8'h10, 1);
    chk("R3 rising clear while high", 32'(nmi), 0);
    wr(8'h0c, 1);
    @(negedge clk); pin = 1'b0;
    @(negedge clk);
    chk("R3 falling set", 32'(nmi), 1);
    wr(8'h10, 1);
    chk("R3 falling clear while low", 32'(nmi), 0);
    wr(8'h0c, 0);
    @(negedge clk);
    chk("R3 level low set", 32'(nmi), 1);
    wr(8'h10, 1);
    chk("R3 level low holds", 32'(nmi), 1);
    wr(8'h0c, 2);
    wr(8'h10, 1);
    chk("R4 final clear", 32'(nmi), 0);
    rchk("R3 trig readback", 8'h0c, 2);
    wr(8'h40, 0);
  endtask

  task automatic t_wake;
    dsrc = 15'h1;
    @(negedge clk);
    chk("R9 idle", 32'(wake), 0);
    wr(8'h40, 32'h2);
    chk("R9 not yet", 32'(wake), 0);
    @(negedge clk);
    chk("R9 asserted", 32'(wake), 1);
    wr(8'h40, 0);
    chk("R9 held one cycle", 32'(wake), 1);
    @(negedge clk);
    chk("R9 dropped", 32'(wake), 0);
    dsrc = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset;
    t_direct;
    t_banked;
    t_mux;
    t_invalid;
    t_pend_ro;
    t_unmapped;
    t_nmi;
    t_wake;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule